// File: doc/BRIEF.md
# Streaming Segmented Scan and Reduction Unit

This block takes a vector as a stream, one element per cycle, and computes one of four combining operations over it: a wrapping sum of the whole vector, an exclusive prefix sum, an exclusive prefix sum that restarts wherever a segment begins, or a signed maximum of the whole vector. Each element carries a flag that marks the start of a segment and a flag that marks the end of the vector. The operation is chosen by a two-bit mode input, which is held steady for the whole of a vector.

Each accepted element produces exactly one output element one cycle later, in the same order, over a valid/ready stream. In the two scan modes the output carries the running prefix value. In the two reduce modes the output returns the element unchanged, and a separate result port pulses once with the reduction of the whole vector. A stalled output stream stops the input from being accepted.

Top module: `scan_unit`

## Requirements
- R1: After reset, out_valid and red_valid are low, in_ready is high, and the first element accepted after reset is combined as the first element of a new vector.
- R2: With mode 0 (sum reduce), the output stream returns each element unchanged, and the cycle after the last element is accepted red_data holds the sum of every element of the vector, wrapping modulo 2^32.
- R3: With mode 1 (exclusive scan), each output is the wrapping sum of all earlier elements of the vector, so the first output is 0, and the segment-start flag has no effect on the output.
- R4: With mode 2 (segmented scan), an element with the segment-start flag set outputs 0, and every later element outputs the sum of the earlier elements of its own segment only.
- R5: With mode 3 (max reduce), the output stream returns each element unchanged, and the cycle after the last element red_data holds the largest element compared as signed 32-bit values.
- R6: Accepting an element with the last flag clears the running value, so the next vector starts as if after reset.
- R7: Every element accepted in one cycle appears on the output in the following cycle with out_valid high, in input order, with out_last equal to its last flag.
- R8: While out_valid is high and out_ready is low, in_ready is low and out_data and out_last hold their values.
- R9: red_valid is high for exactly the one cycle after a last element is accepted in mode 0 or mode 3, and is low in every other cycle, including after a last element in modes 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 sum reduce, 1 exclusive scan, 2 segmented scan, 3 max reduce |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Input element can be taken this cycle |
| in_data | input | 32 | Input element, two's complement |
| in_seg_start | input | 1 | Element opens a new segment |
| in_last | input | 1 | Element ends the vector |
| out_valid | output | 1 | Output element present |
| out_ready | input | 1 | Consumer takes the output element |
| out_data | output | 32 | Prefix value or passed-through element |
| out_last | output | 1 | Output element ends the vector |
| red_valid | output | 1 | One-cycle pulse marking a reduction result |
| red_data | output | 32 | Reduction result of the vector |

## Verification
Vectors are run in each of the four modes: a scan with mixed signs and one whose elements carry segment flags that must be ignored, a segmented scan with three segments including one of length one at the end, a max over all-negative values that catches an unsigned compare, and a sum that overflows past the largest positive value to check wrapping. A one-element vector that follows another vector separates a cleared running value from a stale one. A directed stall holds out_ready low across several cycles with a second element waiting, which tells a held output from one that is overwritten or dropped, and a reset in the middle of a vector shows that the running value does not survive it.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        OP_SUM_RED  = 2'd0,
        OP_XSCAN    = 2'd1,
        OP_SEG_SCAN = 2'd2,
        OP_MAX_RED  = 2'd3
    } scan_op_e;

    function automatic logic op_is_reduce(scan_op_e op);
        return (op == OP_SUM_RED) || (op == OP_MAX_RED);
    endfunction

endpackage

// File: rtl/scan_combine.sv
module scan_combine
    import scan_pkg::*;
#(
    parameter int DW = 32
) (
    input  scan_op_e        op,
    input  logic [DW-1:0]   run_val,
    input  logic            fresh,
    input  logic [DW-1:0]   elem,
    input  logic            seg_open,
    output logic [DW-1:0]   emit_val,
    output logic [DW-1:0]   run_next,
    output logic            reduce_op
);

    logic [DW-1:0] sum_w;
    logic          elem_bigger;

    always_comb begin
        sum_w       = run_val + elem;
        elem_bigger = $signed(elem) > $signed(run_val);
        reduce_op   = op_is_reduce(op);
        emit_val    = elem;
        run_next    = sum_w;
        case (op)
            OP_SUM_RED: begin
                emit_val = elem;
                run_next = sum_w;
            end
            OP_XSCAN: begin
                emit_val = run_val;
                run_next = sum_w;
            end
            OP_SEG_SCAN: begin
                emit_val = seg_open ? '0 : run_val;
                run_next = seg_open ? elem : sum_w;
            end
            OP_MAX_RED: begin
                emit_val = elem;
                run_next = (fresh || elem_bigger) ? elem : run_val;
            end
            default: begin
                emit_val = elem;
                run_next = sum_w;
            end
        endcase
    end

endmodule

// File: rtl/scan_stage.sv
module scan_stage #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DW-1:0]   load_data,
    input  logic            load_last,
    input  logic            take,
    output logic            can_load,
    output logic            hold_valid,
    output logic [DW-1:0]   hold_data,
    output logic            hold_last
);

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
        logic          last;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        can_load = !st_q.valid || take;
        if (load && can_load) begin
            st_d.valid = 1'b1;
            st_d.data  = load_data;
            st_d.last  = load_last;
        end else if (take) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_valid = st_q.valid;
    assign hold_data  = st_q.data;
    assign hold_last  = st_q.last;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_valid && !take) |=> (hold_valid && $stable(hold_data) && $stable(hold_last)));

    // R7
    accept_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && can_load) |=> hold_valid);

endmodule

// File: rtl/scan_unit.sv
module scan_unit
    import scan_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [DW-1:0]   in_data,
    input  logic            in_seg_start,
    input  logic            in_last,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [DW-1:0]   out_data,
    output logic            out_last,
    output logic            red_valid,
    output logic [DW-1:0]   red_data
);

    typedef struct packed {
        logic [DW-1:0] run;
        logic          fresh;
        logic          red_v;
        logic [DW-1:0] red_d;
    } acc_t;

    acc_t acc_d, acc_q;

    scan_op_e      op;
    logic          accept;
    logic [DW-1:0] emit_val;
    logic [DW-1:0] run_next;
    logic          reduce_op;

    assign op     = scan_op_e'(mode);
    assign accept = in_valid && in_ready;

    scan_combine #(.DW(DW)) i_combine (
        .op        (op),
        .run_val   (acc_q.run),
        .fresh     (acc_q.fresh),
        .elem      (in_data),
        .seg_open  (in_seg_start),
        .emit_val  (emit_val),
        .run_next  (run_next),
        .reduce_op (reduce_op)
    );

    scan_stage #(.DW(DW)) i_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (in_valid),
        .load_data  (emit_val),
        .load_last  (in_last),
        .take       (out_ready),
        .can_load   (in_ready),
        .hold_valid (out_valid),
        .hold_data  (out_data),
        .hold_last  (out_last)
    );

    always_comb begin
        acc_d       = acc_q;
        acc_d.red_v = 1'b0;
        if (accept) begin
            if (in_last) begin
                acc_d.run   = '0;
                acc_d.fresh = 1'b1;
                acc_d.red_v = reduce_op;
                acc_d.red_d = reduce_op ? run_next : acc_q.red_d;
            end else begin
                acc_d.run   = run_next;
                acc_d.fresh = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '{run: '0, fresh: 1'b1, red_v: 1'b0, red_d: '0};
        end else begin
            acc_q <= acc_d;
        end
    end

    assign red_valid = acc_q.red_v;
    assign red_data  = acc_q.red_d;

    // R6
    last_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_last) |=> (acc_q.run == '0 && acc_q.fresh));

    // R9
    red_with_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        red_valid |-> (out_valid && out_last));

    // R4
    seg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_SEG_SCAN && in_seg_start) |=> (out_data == '0));

endmodule

// File: tb/test_scan_unit.sv
module test_scan_unit;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    mode;
    logic          in_valid;
    logic          in_ready;
    logic [DW-1:0] in_data;
    logic          in_seg_start;
    logic          in_last;
    logic          out_valid;
    logic          out_ready;
    logic [DW-1:0] out_data;
    logic          out_last;
    logic          red_valid;
    logic [DW-1:0] red_data;

    int nchk  = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    scan_unit #(.DW(DW)) i_scan_unit (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_seg_start(in_seg_start), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .red_valid(red_valid), .red_data(red_data)
    );

    typedef struct packed {
        logic [1:0]  m;
        logic [31:0] d;
        logic        s;
        logic        l;
        logic [31:0] eo;
        logic        rv;
        logic [31:0] er;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t TBL [NV] = '{
        // exclusive scan, mixed signs
        '{2'd1, 32'd5,          1'b0, 1'b0, 32'd0,          1'b0, 32'd0},
        '{2'd1, 32'd3,          1'b0, 1'b0, 32'd5,          1'b0, 32'd0},
        '{2'd1, 32'hFFFF_FFFE,  1'b0, 1'b0, 32'd8,          1'b0, 32'd0},
        '{2'd1, 32'd10,         1'b0, 1'b1, 32'd6,          1'b0, 32'd0},
        // sum reduce
        '{2'd0, 32'd7,          1'b0, 1'b0, 32'd7,          1'b0, 32'd0},
        '{2'd0, 32'd8,          1'b0, 1'b0, 32'd8,          1'b0, 32'd0},
        '{2'd0, 32'hFFFF_FFEC,  1'b0, 1'b1, 32'hFFFF_FFEC,  1'b1, 32'hFFFF_FFFB},
        // segmented scan, three segments
        '{2'd2, 32'd1,          1'b1, 1'b0, 32'd0,          1'b0, 32'd0},
        '{2'd2, 32'd2,          1'b0, 1'b0, 32'd1,          1'b0, 32'd0},
        '{2'd2, 32'd3,          1'b0, 1'b0, 32'd3,          1'b0, 32'd0},
        '{2'd2, 32'd4,          1'b1, 1'b0, 32'd0,          1'b0, 32'd0},
        '{2'd2, 32'd5,          1'b0, 1'b0, 32'd4,          1'b0, 32'd0},
        '{2'd2, 32'd6,          1'b1, 1'b1, 32'd0,          1'b0, 32'd0},
        // max reduce, all negative
        '{2'd3, 32'hFFFF_FFFB,  1'b0, 1'b0, 32'hFFFF_FFFB,  1'b0, 32'd0},
        '{2'd3, 32'hFFFF_FFF7,  1'b0, 1'b0, 32'hFFFF_FFF7,  1'b0, 32'd0},
        '{2'd3, 32'hFFFF_FFFD,  1'b0, 1'b0, 32'hFFFF_FFFD,  1'b0, 32'd0},
        '{2'd3, 32'hFFFF_FFF9,  1'b0, 1'b1, 32'hFFFF_FFF9,  1'b1, 32'hFFFF_FFFD},
        // exclusive scan ignores segment flags
        '{2'd1, 32'd2,          1'b0, 1'b0, 32'd0,          1'b0, 32'd0},
        '{2'd1, 32'd4,          1'b1, 1'b0, 32'd2,          1'b0, 32'd0},
        '{2'd1, 32'd6,          1'b0, 1'b1, 32'd6,          1'b0, 32'd0},
        // sum wraps
        '{2'd0, 32'h7FFF_FFFF,  1'b0, 1'b0, 32'h7FFF_FFFF,  1'b0, 32'd0},
        '{2'd0, 32'd1,          1'b0, 1'b1, 32'd1,          1'b1, 32'h8000_0000},
        // signed max
        '{2'd3, 32'd1,          1'b0, 1'b0, 32'd1,          1'b0, 32'd0},
        '{2'd3, 32'hFFFF_FFFF,  1'b0, 1'b1, 32'hFFFF_FFFF,  1'b1, 32'd1},
        // single element vector, no segment flag
        '{2'd2, 32'd9,          1'b0, 1'b1, 32'd0,          1'b0, 32'd0}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string mode_req(logic [1:0] m);
        case (m)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = 2'd0; in_valid = 1'b0; in_data = '0;
        in_seg_start = 1'b0; in_last = 1'b0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {31'd0, out_valid}, 32'd0);
        chk("R1", {31'd0, red_valid}, 32'd0);
        chk("R1", {31'd0, in_ready},  32'd1);

        // table walk, R6 via back-to-back vectors
        for (int i = 0; i < NV; i++) begin
            mode = TBL[i].m; in_data = TBL[i].d;
            in_seg_start = TBL[i].s; in_last = TBL[i].l; in_valid = 1'b1;
            @(negedge clk);
            chk("R7", {31'd0, out_valid}, 32'd1);
            chk("R7", {31'd0, out_last}, {31'd0, TBL[i].l});
            chk((i == NV - 1) ? "R6" : mode_req(TBL[i].m), out_data, TBL[i].eo);
            chk("R9", {31'd0, red_valid}, {31'd0, TBL[i].rv});
            if (TBL[i].rv) chk(mode_req(TBL[i].m), red_data, TBL[i].er);
        end
        in_valid = 1'b0; in_last = 1'b0; in_seg_start = 1'b0;
        @(negedge clk);
        chk("R7", {31'd0, out_valid}, 32'd0);
        chk("R9", {31'd0, red_valid}, 32'd0);

        // R8 stall with a waiting element
        mode = 2'd1; out_ready = 1'b0;
        in_data = 32'd4; in_last = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        chk("R8", out_data, 32'd0);
        in_data = 32'd6; in_last = 1'b1;
        @(negedge clk);
        chk("R8", {31'd0, in_ready}, 32'd0);
        chk("R8", out_data, 32'd0);
        chk("R8", {31'd0, out_last}, 32'd0);
        @(negedge clk);
        chk("R8", out_data, 32'd0);
        chk("R8", {31'd0, out_valid}, 32'd1);
        out_ready = 1'b1;
        @(negedge clk);
        chk("R8", out_data, 32'd4);
        chk("R8", {31'd0, out_last}, 32'd1);
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);
        chk("R7", {31'd0, out_valid}, 32'd0);

        // R1 reset in the middle of a vector
        in_data = 32'd11; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        in_data = 32'd2; in_last = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        chk("R1", out_data, 32'd0);
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule